// File: doc/BRIEF.md
# Four-Value Signed-Digit Coefficient Recoder

This block turns a two's-complement coefficient word into the compact signed-digit code that a pre-encoded multiplier keeps in its coefficient store. The word is read as radix-4 digits. Every digit except the top one takes one of only four values, so it needs just two stored bits. The top digit keeps the five-value Booth range and is stored as three flag bits. For a word of `WIDTH` bits the code is therefore `WIDTH+1` bits wide.

A per-word select input chooses one of two digit sets. With the select low the lower digits lie in {-2,-1,0,+1}. With it high they lie in {-1,0,+1,+2}. The recoding runs as a ripple through pairs of half adders. One adder of each pair is a plain half adder. The other is a modified adder whose carry is the OR of its inputs and whose sum counts negatively. The ripple bit left over after the last pair feeds the Booth encoding of the top digit. The code is held in an output register by default. A parameter can remove that register to give a purely combinational path.

Top module: `nr4_recoder`

## Requirements
- R1: While `rst_n` is low, `code_out` is all zeros.
- R2: With the output register present, the code for the `word_in` and `set_plus` sampled at a rising edge appears on `code_out` after that edge. It stays there until the next edge.
- R3: With `set_plus` = 0, lower digit j (j < WIDTH/2-1) is held in bits [2j+1:2j]. Bit 2j+1 weighs -2 and bit 2j weighs +1, so the digit lies in {-2,-1,0,+1}.
- R4: With `set_plus` = 1, lower digit j is held in bits [2j+1:2j]. Bit 2j+1 weighs +2 and bit 2j weighs -1, so the digit lies in {-1,0,+1,+2}.
- R5: The top digit occupies bits [WIDTH:WIDTH-2] as {sign, two, one}. Its value is (-1)^sign·(one + 2·two). The two and one flags are never both set. The sign flag equals the most significant bit of the word.
- R6: For every input word in both digit sets, the sum of digit_j·4^j over all digits equals the signed value of the word.
- R7: A zero word produces an all-zero code in both digit sets.
- R8: The most negative word (only the top bit set) produces lower digits of zero and a top digit of -2 in both digit sets.
- R9: The digit set can change on every clock. Each code follows the select value that was sampled together with its own word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| set_plus | input | 1 | Digit-set select: 0 gives {-2..+1}, 1 gives {-1..+2} |
| word_in | input | WIDTH | Two's-complement coefficient |
| code_out | output | WIDTH+1 | Packed signed-digit code |

## Verification
A change of digit set and a change of word can land in the same cycle. The bench provokes this by toggling `set_plus` on every clock while it steps through every 16-bit word. Each code must match a behavioural reference built from the select value that was registered with that word, and must also sum back to the word. The ripple bit that enters the top digit changes in that same cycle, so the Booth fields are judged against the word's own top bit and against the remainder left by the reference's digit-by-digit division.

// File: rtl/nr4_pkg.sv
package nr4_pkg;

    typedef enum logic {
        SET_MINUS = 1'b0,
        SET_PLUS  = 1'b1
    } digit_set_e;

    typedef struct packed {
        logic sign;
        logic two;
        logic one;
    } top_digit_s;

endpackage

// File: rtl/nr4_pair_cell.sv
module nr4_pair_cell
    import nr4_pkg::*;
(
    input  digit_set_e mode,
    input  logic       b_lo,
    input  logic       b_hi,
    input  logic       c_in,
    output logic       bit_lo,
    output logic       bit_hi,
    output logic       c_out
);

    logic c_mid;

    always_comb begin
        if (mode == SET_MINUS) begin
            // plain adder first, then the negative-sum adder
            c_mid  = b_lo & c_in;
            bit_lo = b_lo ^ c_in;
            bit_hi = b_hi ^ c_mid;
            c_out  = b_hi | c_mid;
        end else begin
            // negative-sum adder first, then the plain adder
            c_mid  = b_lo | c_in;
            bit_lo = b_lo ^ c_in;
            bit_hi = b_hi ^ c_mid;
            c_out  = b_hi & c_mid;
        end
    end

    int digit_val;
    always_comb begin
        if (mode == SET_MINUS) digit_val = -2 * int'(bit_hi) + int'(bit_lo);
        else                   digit_val =  2 * int'(bit_hi) - int'(bit_lo);
        AST_PAIR_BALANCE: assert (int'(b_lo) + 2 * int'(b_hi) + int'(c_in)
                                  == digit_val + 4 * int'(c_out)); // R6
    end

endmodule

// File: rtl/nr4_top_booth.sv
module nr4_top_booth
    import nr4_pkg::*;
(
    input  logic       b_hi,
    input  logic       b_lo,
    input  logic       c_in,
    output top_digit_s digit
);

    always_comb begin
        digit.sign = b_hi;
        digit.one  = b_lo ^ c_in;
        digit.two  = (b_lo == c_in) && (b_hi != b_lo);
    end

    int in_val;
    int out_val;
    always_comb begin
        in_val  = -2 * int'(b_hi) + int'(b_lo) + int'(c_in);
        out_val = int'(digit.one) + 2 * int'(digit.two);
        if (digit.sign) out_val = -out_val;
        AST_TOP_FLAGS_EXCL: assert (!(digit.one && digit.two)); // R5
        AST_TOP_VALUE: assert (in_val == out_val); // R5
    end

endmodule

// File: rtl/nr4_recoder.sv
module nr4_recoder
    import nr4_pkg::*;
#(
    parameter int WIDTH   = 16,
    parameter bit REG_OUT = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_plus,
    input  logic [WIDTH-1:0] word_in,
    output logic [WIDTH:0]   code_out
);

    localparam int DIGITS = WIDTH / 2;
    localparam int LOWER  = DIGITS - 1;
    localparam int CODE_W = WIDTH + 1;

    typedef struct packed {
        logic [CODE_W-1:0] code;
    } stage_s;

    digit_set_e        mode;
    logic [LOWER:0]    ripple;
    logic [CODE_W-1:0] code_comb;
    top_digit_s        top_digit;

    assign mode      = digit_set_e'(set_plus);
    assign ripple[0] = 1'b0;

    for (genvar j = 0; j < LOWER; j++) begin : g_pair
        nr4_pair_cell i_cell (
            .mode   (mode),
            .b_lo   (word_in[2*j]),
            .b_hi   (word_in[2*j+1]),
            .c_in   (ripple[j]),
            .bit_lo (code_comb[2*j]),
            .bit_hi (code_comb[2*j+1]),
            .c_out  (ripple[j+1])
        );
    end

    nr4_top_booth i_top (
        .b_hi  (word_in[WIDTH-1]),
        .b_lo  (word_in[WIDTH-2]),
        .c_in  (ripple[LOWER]),
        .digit (top_digit)
    );

    assign code_comb[CODE_W-1:CODE_W-3] = top_digit;

    function automatic int code_value(logic [CODE_W-1:0] c, logic plus);
        int acc;
        int w;
        int t;
        acc = 0;
        w   = 1;
        for (int j = 0; j < LOWER; j++) begin
            if (plus) acc += w * (2 * int'(c[2*j+1]) - int'(c[2*j]));
            else      acc += w * (int'(c[2*j]) - 2 * int'(c[2*j+1]));
            w *= 4;
        end
        t = int'(c[CODE_W-3]) + 2 * int'(c[CODE_W-2]);
        if (c[CODE_W-1]) t = -t;
        return acc + w * t;
    endfunction

    if (REG_OUT) begin : g_reg
        stage_s stage_d;
        stage_s stage_q;

        always_comb begin
            stage_d      = stage_q;
            stage_d.code = code_comb;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q <= '0;
            else        stage_q <= stage_d;
        end

        assign code_out = stage_q.code;

        AST_RESET_CLEAR: assert property (@(posedge clk)
            !rst_n |-> code_out == '0); // R1
        AST_VALUE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n) |-> code_value(code_out, $past(set_plus))
                             == int'($signed($past(word_in)))); // R2
        AST_ZERO_WORD: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(word_in) == '0) |-> code_out == '0); // R7
        AST_TOP_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(code_out[CODE_W-2:CODE_W-3])); // R5
    end else begin : g_comb
        assign code_out = code_comb;
    end

endmodule

// File: tb/test_nr4_recoder.sv
module test_nr4_recoder;

    localparam int WIDTH  = 16;
    localparam int DIGITS = WIDTH / 2;
    localparam int CODE_W = WIDTH + 1;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              set_plus = 1'b0;
    logic [WIDTH-1:0]  word_in = '0;
    logic [CODE_W-1:0] code_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [CODE_W-1:0] exp_q[$];
    logic [WIDTH-1:0]  word_q[$];
    logic              mode_q[$];

    nr4_recoder #(.WIDTH(WIDTH), .REG_OUT(1'b1)) i_nr4_recoder (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_plus (set_plus),
        .word_in  (word_in),
        .code_out (code_out)
    );

    always #5 clk = ~clk;

    // Behavioural reference: repeated division by four with a digit-set window.
    function automatic logic [CODE_W-1:0] ref_code(logic [WIDTH-1:0] w, logic plus);
        logic [CODE_W-1:0] c;
        int r;
        int m;
        int d;
        c = '0;
        r = int'($signed(w));
        for (int j = 0; j < DIGITS - 1; j++) begin
            m = r & 3;
            if (plus) d = (m == 3) ? -1 : m;
            else      d = (m >= 2) ? m - 4 : m;
            r = (r - d) / 4;
            if (plus) begin
                c[2*j+1] = (d >= 1);
                c[2*j]   = (d == 1) || (d == -1);
            end else begin
                c[2*j+1] = (d < 0);
                c[2*j]   = (d == 1) || (d == -1);
            end
        end
        c[CODE_W-1] = w[WIDTH-1];
        c[CODE_W-2] = (r == 2) || (r == -2);
        c[CODE_W-3] = (r == 1) || (r == -1);
        return c;
    endfunction

    function automatic int sum_digits(logic [CODE_W-1:0] c, logic plus);
        int acc;
        int wt;
        int t;
        acc = 0;
        wt  = 1;
        for (int j = 0; j < DIGITS - 1; j++) begin
            if (plus) acc += wt * (2 * int'(c[2*j+1]) - int'(c[2*j]));
            else      acc += wt * (int'(c[2*j]) - 2 * int'(c[2*j+1]));
            wt *= 4;
        end
        t = int'(c[CODE_W-3]) + 2 * int'(c[CODE_W-2]);
        if (c[CODE_W-1]) t = -t;
        return acc + wt * t;
    endfunction

    task automatic check_code(string tag, logic [CODE_W-1:0] act, logic [CODE_W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: code actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic check_int(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Called at a falling edge: compare the oldest pending result, then drive.
    task automatic step(logic [WIDTH-1:0] w, logic plus, bit drive);
        logic [CODE_W-1:0] e;
        logic [WIDTH-1:0]  pw;
        logic              pm;
        if (exp_q.size() > 0) begin
            e  = exp_q.pop_front();
            pw = word_q.pop_front();
            pm = mode_q.pop_front();
            check_code(pm ? "R4/R9 plus code" : "R3/R9 minus code", code_out, e);
            check_int("R6 digit sum", sum_digits(code_out, pm), int'($signed(pw)));
            checks++;
            if (code_out[CODE_W-2] && code_out[CODE_W-3]) begin
                errors++;
                $display("FAIL R5: top flags both set actual=%b expected=not 11",
                         code_out[CODE_W-2:CODE_W-3]);
            end
        end
        if (drive) begin
            word_in  = w;
            set_plus = plus;
            exp_q.push_back(ref_code(w, plus));
            word_q.push_back(w);
            mode_q.push_back(plus);
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        // R1: reset holds the code at zero even with a busy input
        word_in  = 16'hA5C3;
        set_plus = 1'b1;
        repeat (3) begin
            @(negedge clk);
            check_code("R1 reset", code_out, '0);
        end
        @(negedge clk);
        rst_n = 1'b1;

        // R7: zero word in both sets
        step(16'h0000, 1'b0, 1'b1);
        @(negedge clk); begin
            check_code("R7 zero minus", code_out, '0);
            step(16'h0000, 1'b1, 1'b1);
            void'(exp_q.pop_front()); void'(word_q.pop_front()); void'(mode_q.pop_front());
        end
        @(negedge clk);
        check_code("R7 zero plus", code_out, '0);
        exp_q.delete(); word_q.delete(); mode_q.delete();

        // R8: most negative word -> lower digits zero, top digit -2
        word_in = 16'h8000; set_plus = 1'b0;
        @(negedge clk);
        check_code("R8 min minus", code_out, 17'h18000);
        check_int("R8 min minus sum", sum_digits(code_out, 1'b0), -32768);
        set_plus = 1'b1;
        @(negedge clk);
        check_code("R8 min plus", code_out, 17'h18000);

        // R2: code changes only after the edge and then holds
        word_in = 16'h0001; set_plus = 1'b0;
        @(posedge clk); #2;
        check_code("R2 after edge", code_out, ref_code(16'h0001, 1'b0));
        word_in = 16'h7FFF;
        #2;
        check_code("R2 holds between edges", code_out, ref_code(16'h0001, 1'b0));
        @(negedge clk);
        check_code("R2 no early change", code_out, ref_code(16'h0001, 1'b0));

        // R3 R4 R5 R6 R9: every word, digit set toggling on each cycle
        for (int i = 0; i < 2 * 65536; i++) begin
            step(16'(i >> 1), (i & 1) != 0, 1'b1);
            @(negedge clk);
        end
        step('0, 1'b0, 1'b0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule